// File: doc/BRIEF.md
# Imprecise Exception Drain Controller

This block sits between a core's in-order issue stage and a set of functional units that may finish their work in any order. It watches the completion pulses of every unit. When a completing operation reports one or more exception kinds, the block stops further issue at once and records the address of the next instruction the core would have run.

The block then waits until every unit still working has finished. Operations that finish during this wait may report more exceptions. Those kinds are merged into the same set of sticky per-kind flags, so a single trap can stand for several exceptions from several units. Once no unit is busy, the block raises one trap request and holds it until the core acknowledges it.

The flags record which kinds of exception occurred. They do not record how many of each occurred or which operation raised them. They stay set until software clears them. The saved address is the only location information handed to the trap handler.

Top module: `exc_drain_ctrl`

## Requirements
- R1: After reset, `issue_block_o`, `trap_req_o`, `flags_o` and `saved_pc_o` are all zero.
- R2: The exception bits of unit u count only in a cycle where `done_i[u]` is 1. Exception bits driven while `done_i[u]` is 0 change neither the flags nor the issue block.
- R3: While idle, a qualified exception raises `issue_block_o` combinationally in the same cycle. The signal stays high through draining and trapping, and drops in the cycle after the trap is acknowledged.
- R4: `saved_pc_o` takes the value of `next_pc_i` from the cycle of the first exception. Later values of `next_pc_i` do not change it. It keeps that value until the next first exception after an acknowledged trap.
- R5: Each unit drives a 5-bit exception field in `exc_i`, at bits [5u+4:5u]. In each field, bit 0 is invalid, bit 1 is divide-by-zero, bit 2 is overflow, bit 3 is underflow and bit 4 is inexact. All qualified fields from one cycle are ORed into `flags_o`, which shows the result one cycle later. Flag bits stay set.
- R6: During draining, no trap is requested while any bit of `busy_i` is 1. `trap_req_o` rises in the cycle after the first draining cycle in which `busy_i` is all zero. The first draining cycle is the cycle after the first exception.
- R7: Exceptions that complete during draining are merged into the flags that accompany the pending trap, without a new address capture.
- R8: `trap_req_o` stays high until a cycle with `trap_ack_i` = 1. In the following cycle, `trap_req_o` is low.
- R9: `flag_clr_i` zeroes `flags_o` in the next cycle. Any qualified exception in the same cycle still sets its bits.
- R10: `trap_ack_i` has no effect while idle or while draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | NUM_UNITS | Per-unit completion pulse |
| exc_i | input | NUM_UNITS*5 | Per-unit exception kinds, valid with done_i |
| busy_i | input | NUM_UNITS | Per-unit operation-in-progress flags |
| next_pc_i | input | PC_W | Address of the next instruction to run |
| trap_ack_i | input | 1 | Core accepts the pending trap |
| flag_clr_i | input | 1 | Software clear of the sticky flags |
| issue_block_o | output | 1 | Stops the core from issuing |
| trap_req_o | output | 1 | One merged trap is pending |
| flags_o | output | 5 | Sticky exception-kind flags |
| saved_pc_o | output | PC_W | Resume address captured at the first exception |

## Verification
The bench first sends a first exception while one unit is still busy. A second unit then completes with a different kind in the same cycle that the busy vector empties. A design that took the trap early would show only the first kind. A design that captured the address again would show a later address.

Further cases are:
- two units reporting in one cycle, which catches a design that keeps only one unit's field;
- exception bits driven without a completion pulse, which catches a design that fails to qualify them;
- an acknowledge sent while idle or draining, which catches a design that ends the drain early;
- a clear in the same cycle as a new exception, which catches a design that lets the clear win.

// File: rtl/exc_drain_pkg.sv
package exc_drain_pkg;
  localparam int unsigned FLAG_W = 5;
  localparam int unsigned F_INV  = 0;
  localparam int unsigned F_DZ   = 1;
  localparam int unsigned F_OVF  = 2;
  localparam int unsigned F_UNF  = 3;
  localparam int unsigned F_INX  = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_TRAP  = 2'd2
  } drain_state_e;
endpackage

// File: rtl/exc_collect.sv
module exc_collect
  import exc_drain_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 4,
  localparam int unsigned EXC_W = NUM_UNITS * FLAG_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_UNITS-1:0] done_i,
  input  logic [EXC_W-1:0]     exc_i,
  output logic [FLAG_W-1:0]    new_exc_o,
  output logic                 any_exc_o
);
  logic [FLAG_W-1:0] masked [NUM_UNITS];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign masked[u] = done_i[u] ? exc_i[u*FLAG_W +: FLAG_W] : '0;
  end

  always_comb begin
    new_exc_o = '0;
    for (int u = 0; u < NUM_UNITS; u++) new_exc_o |= masked[u];
  end

  assign any_exc_o = |new_exc_o;

  // R2
  unqualified_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i == '0) |-> !any_exc_o);
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags
  import exc_drain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [FLAG_W-1:0] set_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (clr_i ? '0 : flags_q) | set_i;
  end

  assign flags_o = flags_q;

  // R5
  flags_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R9
  clear_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (flags_q == $past(set_i)));
endmodule

// File: rtl/pc_hold.sv
module pc_hold #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (cap_i) pc_q <= pc_i;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/drain_fsm.sv
module drain_fsm
  import exc_drain_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 any_exc_i,
  input  logic [NUM_UNITS-1:0] busy_i,
  input  logic                 ack_i,
  output logic                 capture_o,
  output logic                 issue_block_o,
  output logic                 trap_req_o
);
  drain_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (any_exc_i)      state_d = ST_DRAIN;
      ST_DRAIN: if (busy_i == '0)   state_d = ST_TRAP;
      ST_TRAP:  if (ack_i)          state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign capture_o     = (state_q == ST_IDLE) && any_exc_i;
  assign issue_block_o = (state_q != ST_IDLE) || any_exc_i;
  assign trap_req_o    = (state_q == ST_TRAP);

  // R6
  trap_after_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trap_req_o) |-> ($past(busy_i) == '0));
  // R3
  block_during_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> issue_block_o);
  // R8
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_o && ack_i) |=> !trap_req_o);
  // R10
  ack_idle_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_req_o && !capture_o && !issue_block_o && ack_i) |=> !trap_req_o);
endmodule

// File: rtl/exc_drain_ctrl.sv
module exc_drain_ctrl
  import exc_drain_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned PC_W      = 32,
  localparam int unsigned EXC_W    = NUM_UNITS * FLAG_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_UNITS-1:0] done_i,
  input  logic [EXC_W-1:0]     exc_i,
  input  logic [NUM_UNITS-1:0] busy_i,
  input  logic [PC_W-1:0]      next_pc_i,
  input  logic                 trap_ack_i,
  input  logic                 flag_clr_i,
  output logic                 issue_block_o,
  output logic                 trap_req_o,
  output logic [FLAG_W-1:0]    flags_o,
  output logic [PC_W-1:0]      saved_pc_o
);
  logic [FLAG_W-1:0] new_exc;
  logic              any_exc;
  logic              capture;

  exc_collect #(.NUM_UNITS(NUM_UNITS)) u_collect (
    .clk_i, .rst_ni, .done_i, .exc_i,
    .new_exc_o(new_exc), .any_exc_o(any_exc)
  );

  drain_fsm #(.NUM_UNITS(NUM_UNITS)) u_fsm (
    .clk_i, .rst_ni, .any_exc_i(any_exc), .busy_i, .ack_i(trap_ack_i),
    .capture_o(capture), .issue_block_o, .trap_req_o
  );

  sticky_flags u_flags (
    .clk_i, .rst_ni, .clr_i(flag_clr_i), .set_i(new_exc), .flags_o
  );

  pc_hold #(.PC_W(PC_W)) u_pc (
    .clk_i, .rst_ni, .cap_i(capture), .pc_i(next_pc_i), .pc_o(saved_pc_o)
  );

  // R4
  pc_stable_in_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_o && $past(trap_req_o)) |-> $stable(saved_pc_o));
  // R7
  flags_nonzero_at_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(trap_req_o) && !$past(flag_clr_i)) |-> (flags_o != '0));
endmodule

// File: tb/tb_exc_drain_ctrl.sv
module tb_exc_drain_ctrl;
  localparam int unsigned NU = 4;
  localparam int unsigned PW = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NU-1:0]   done_i = '0;
  logic [NU*5-1:0] exc_i = '0;
  logic [NU-1:0]   busy_i = '0;
  logic [PW-1:0]   next_pc_i = '0;
  logic            trap_ack_i = 1'b0;
  logic            flag_clr_i = 1'b0;
  logic            issue_block_o, trap_req_o;
  logic [4:0]      flags_o;
  logic [PW-1:0]   saved_pc_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [36:0] exp_q[$];  // {flags, pc}

  always #5 clk_i = ~clk_i;

  exc_drain_ctrl #(.NUM_UNITS(NU), .PC_W(PW)) dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drv(input logic [NU-1:0] d, input logic [NU*5-1:0] e, input logic [NU-1:0] b,
                     input logic [PW-1:0] pc, input logic ack, input logic clr);
    @(negedge clk_i);
    done_i = d; exc_i = e; busy_i = b; next_pc_i = pc; trap_ack_i = ack; flag_clr_i = clr;
    #1;
  endtask

  // monitor: each trap rise pops one expected record
  logic prev_req = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni && trap_req_o && !prev_req) begin
      if (exp_q.size() == 0) check("R6 unexpected trap", 64'd1, 64'd0);
      else begin
        logic [36:0] it;
        it = exp_q.pop_front();
        check("R7 trap flags", 64'(flags_o), 64'(it[36:32]));
        check("R4 trap pc", 64'(saved_pc_o), 64'(it[31:0]));
      end
    end
    prev_req = trap_req_o;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    drv('0, '0, '0, 0, 0, 0);
    // R1
    check("R1 issue_block", 64'(issue_block_o), 0);
    check("R1 trap_req", 64'(trap_req_o), 0);
    check("R1 flags", 64'(flags_o), 0);
    check("R1 saved_pc", 64'(saved_pc_o), 0);

    // R2: exception bits without completion
    drv('0, 20'h00010, 4'b0011, 32'h50, 0, 0);
    check("R2 no block", 64'(issue_block_o), 0);
    drv('0, '0, '0, 0, 0, 0);
    check("R2 flags untouched", 64'(flags_o), 0);

    // Drain with merge: inexact on unit0 while unit1 busy
    exp_q.push_back({5'h14, 32'h100});
    drv(4'b0001, 20'h00010, 4'b0010, 32'h100, 0, 0);
    check("R3 same-cycle block", 64'(issue_block_o), 1);
    drv('0, '0, 4'b0010, 32'h104, 1, 0);        // ack while draining
    check("R5 flag inexact", 64'(flags_o), 5'h10);
    check("R4 captured pc", 64'(saved_pc_o), 32'h100);
    check("R6 no trap while busy", 64'(trap_req_o), 0);
    drv('0, '0, 4'b0010, 32'h108, 0, 0);
    check("R10 ack in drain ignored", 64'(trap_req_o), 0);
    check("R3 still blocked", 64'(issue_block_o), 1);
    drv(4'b0010, 20'h00080, '0, 32'h10c, 0, 0); // overflow on unit1, busy empties
    check("R6 no trap yet", 64'(trap_req_o), 0);
    drv('0, '0, '0, 32'h110, 0, 0);
    check("R6 trap raised", 64'(trap_req_o), 1);
    check("R7 merged flags", 64'(flags_o), 5'h14);
    drv('0, '0, '0, 32'h114, 0, 0);
    check("R8 trap held", 64'(trap_req_o), 1);
    check("R4 pc held", 64'(saved_pc_o), 32'h100);
    drv('0, '0, '0, 32'h118, 1, 0);
    check("R8 still high in ack cycle", 64'(trap_req_o), 1);
    drv('0, '0, '0, 32'h11c, 0, 0);
    check("R8 released", 64'(trap_req_o), 0);
    check("R3 unblocked", 64'(issue_block_o), 0);
    check("R5 flags sticky", 64'(flags_o), 5'h14);
    check("R4 pc kept after ack", 64'(saved_pc_o), 32'h100);

    // R10: ack while idle
    drv('0, '0, '0, 32'h120, 1, 0);
    drv('0, '0, '0, 32'h124, 0, 0);
    check("R10 idle ack no trap", 64'(trap_req_o), 0);
    check("R10 idle ack flags", 64'(flags_o), 5'h14);

    // R9: clear alone
    drv('0, '0, '0, 32'h128, 0, 1);
    drv('0, '0, '0, 32'h12c, 0, 0);
    check("R9 clear", 64'(flags_o), 0);

    // R5: two units in one cycle (unit1 invalid, unit3 divide-by-zero)
    exp_q.push_back({5'h03, 32'h200});
    drv(4'b1010, 20'h10020, '0, 32'h200, 0, 0);
    check("R3 block multi", 64'(issue_block_o), 1);
    drv('0, '0, '0, 32'h204, 0, 0);
    check("R5 OR of units", 64'(flags_o), 5'h03);
    check("R6 first drain cycle", 64'(trap_req_o), 0);
    drv('0, '0, '0, 32'h208, 0, 0);
    check("R6 trap multi", 64'(trap_req_o), 1);
    drv('0, '0, '0, 32'h20c, 1, 0);
    drv('0, '0, '0, 32'h210, 0, 0);
    check("R8 released multi", 64'(trap_req_o), 0);

    // R9: clear with simultaneous underflow on unit2
    exp_q.push_back({5'h08, 32'h300});
    drv(4'b0100, 20'h02000, 4'b0001, 32'h300, 0, 1);
    drv('0, 20'h00001, 4'b0001, 32'h304, 0, 0);  // unqualified bits during drain
    check("R9 set wins over clear", 64'(flags_o), 5'h08);
    drv('0, '0, '0, 32'h308, 0, 0);
    check("R2 drain unqualified ignored", 64'(flags_o), 5'h08);
    drv('0, '0, '0, 32'h30c, 0, 0);
    check("R6 trap after clear case", 64'(trap_req_o), 1);
    drv('0, '0, '0, 32'h310, 1, 0);
    drv('0, '0, '0, 32'h314, 0, 0);
    check("R8 released final", 64'(trap_req_o), 0);

    drv('0, '0, '0, 0, 0, 0);
    check("R6 all traps seen", 64'(exp_q.size()), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule